// File: doc/BRIEF.md
# ROM Search Triplet Sequencer

This block carries out a single bit position of a single-wire bus ROM search. It runs three bus slots in order. The first two are read slots, which drive a 1 and sample the line. They capture the ID bit that the devices present and then its complement. The block then decides which branch of the search tree to follow and writes that direction back in a third slot. Devices whose ROM bit differs from the written value drop out of the search.

The block has no bus timing of its own. A bit-slot engine below it does the slot timing. The block asks for a slot with a one-cycle request, holds the bit to be driven, and waits for the engine's done strobe together with the sampled line level. The caller above supplies a start strobe and a preferred direction. The preferred direction is used only when the devices disagree. The caller gets back a packed 3-bit status and a one-cycle done pulse. It keeps its own record of where the discrepancies were and builds up the ROM code.

Top module: `srch_triplet`

## Requirements
- R1: While reset is high and in the first cycle after it, `slot_req_o`, `done_o` and `status_o` are all 0.
- R2: After an accepted start the block issues read slots with `slot_bit_o` = 1 twice, then at most one write slot. Each request is a one-cycle pulse on `slot_req_o`. The next request comes only in the cycle after the previous slot's `slot_done_i` has been sampled.
- R3: In the status word, bit 0 holds the sampled ID bit, bit 1 holds the sampled complement bit and bit 2 holds the direction written.
- R4: If both sampled bits are 1, no write slot is issued and the status is 3'b011.
- R5: If both sampled bits are 0, the write slot carries the preferred direction. The status is 3'b100 when that direction is 1 and 3'b000 when it is 0.
- R6: If exactly one sampled bit is 1, the write slot carries the ID bit. The status is 3'b101 when the ID bit is 1 and 3'b010 when it is 0.
- R7: The preferred direction is sampled when start is accepted. Later changes of `pref_dir_i` have no effect. `slot_bit_o` stays stable from a request until that slot's done.
- R8: `done_o` is high for exactly one cycle per triplet, in the same cycle that `status_o` takes its new value. `status_o` does not change at any other time.
- R9: A start strobe that arrives while a triplet is in progress is ignored. No extra slots and no extra done pulse follow from it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin one triplet; acted on only when idle |
| pref_dir_i | input | 1 | Direction to take when both sampled bits are 0 |
| slot_req_o | output | 1 | One-cycle request for a bus slot |
| slot_bit_o | output | 1 | Bit to drive in the requested slot (1 for read slots) |
| slot_done_i | input | 1 | Slot engine finished the outstanding slot |
| slot_rdata_i | input | 1 | Line level the engine sampled in that slot |
| done_o | output | 1 | One-cycle pulse when the status word is updated |
| status_o | output | 3 | {direction, complement bit, ID bit} |

## Verification
The bench plays the slot engine with different latencies and goes through all four combinations of sampled bits, with both preferred directions where they matter. A design that lets the 11 case fall through to a write would issue a third slot. A design that uses the preferred direction when only one bit is set would send the search down a branch where no device exists, and the returned bit 2 would be wrong. The bench changes `pref_dir_i` right after start and pulses start in the middle of a triplet. A design that reads the direction late, or that restarts when busy, would show up as a wrong written bit or as extra slot requests. After each done the bench also watches for leftover requests and status changes.

// File: rtl/srch_triplet_pkg.sv
package srch_triplet_pkg;

    // sequencer states
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ_ID,
        ST_WAIT_ID,
        ST_REQ_CMP,
        ST_WAIT_CMP,
        ST_REQ_WR,
        ST_WAIT_WR
    } step_e;

    // packed result, bit 2 down to bit 0
    typedef struct packed {
        logic dir;
        logic cmp;
        logic id;
    } trip_stat_t;

    localparam int STAT_W = $bits(trip_stat_t);

    typedef enum logic [1:0] {
        DEC_BRANCH,   // devices disagree, caller chooses
        DEC_FORCED,   // all remaining devices agree
        DEC_ABORT     // nobody answered
    } dec_kind_e;

    typedef struct packed {
        dec_kind_e kind;
        logic      dir;
    } decision_t;

    function automatic decision_t resolve(input logic id_b, input logic cmp_b,
                                          input logic pref);
        decision_t d;
        if (id_b && cmp_b) begin
            d.kind = DEC_ABORT;
            d.dir  = 1'b0;
        end else if (!id_b && !cmp_b) begin
            d.kind = DEC_BRANCH;
            d.dir  = pref;
        end else begin
            d.kind = DEC_FORCED;
            d.dir  = id_b;
        end
        return d;
    endfunction

endpackage

// File: rtl/srch_triplet_decide.sv
module srch_triplet_decide
    import srch_triplet_pkg::*;
(
    input  logic      id_b_i,
    input  logic      cmp_b_i,
    input  logic      pref_i,
    output logic      abort_o,
    output logic      dir_o
);
    decision_t dec;

    always_comb begin
        dec     = resolve(id_b_i, cmp_b_i, pref_i);
        abort_o = (dec.kind == DEC_ABORT);
        dir_o   = dec.dir;
    end

    // R4/R6: decision relation between inputs and outputs
    always_comb begin
        if (!abort_o && (id_b_i != cmp_b_i))
            a_forced_r6: assert (dir_o == id_b_i);
    end

endmodule

// File: rtl/srch_triplet_ctrl.sv
module srch_triplet_ctrl
    import srch_triplet_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic slot_done_i,
    input  logic abort_i,
    input  logic wr_dir_i,
    output logic slot_req_o,
    output logic slot_bit_o,
    output logic accept_o,
    output logic cap_id_o,
    output logic cap_cmp_o,
    output logic fin_abort_o,
    output logic fin_wr_o
);
    step_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:     if (start_i) st_d = ST_REQ_ID;
            ST_REQ_ID:   st_d = ST_WAIT_ID;
            ST_WAIT_ID:  if (slot_done_i) st_d = ST_REQ_CMP;
            ST_REQ_CMP:  st_d = ST_WAIT_CMP;
            ST_WAIT_CMP: if (slot_done_i) st_d = abort_i ? ST_IDLE : ST_REQ_WR;
            ST_REQ_WR:   st_d = ST_WAIT_WR;
            ST_WAIT_WR:  if (slot_done_i) st_d = ST_IDLE;
            default:     st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_IDLE;
        else     st_q <= st_d;
    end

    always_comb begin
        slot_req_o  = (st_q == ST_REQ_ID) || (st_q == ST_REQ_CMP) || (st_q == ST_REQ_WR);
        slot_bit_o  = ((st_q == ST_REQ_WR) || (st_q == ST_WAIT_WR)) ? wr_dir_i : 1'b1;
        accept_o    = (st_q == ST_IDLE) && start_i;
        cap_id_o    = (st_q == ST_WAIT_ID) && slot_done_i;
        cap_cmp_o   = (st_q == ST_WAIT_CMP) && slot_done_i;
        fin_abort_o = cap_cmp_o && abort_i;
        fin_wr_o    = (st_q == ST_WAIT_WR) && slot_done_i;
    end

    // R7: driven bit held while a slot is outstanding
    p_bit_stable_r7: assert property (@(posedge clk) disable iff (rst)
        ((st_q == ST_WAIT_WR) && !slot_done_i) |=> $stable(slot_bit_o));

    // R2: requests last a single cycle
    p_req_single_r2: assert property (@(posedge clk) disable iff (rst)
        slot_req_o |=> !slot_req_o);

    // R9: a start while busy does not return to the first slot
    p_busy_start_r9: assert property (@(posedge clk) disable iff (rst)
        ((st_q == ST_WAIT_CMP) && start_i && !slot_done_i) |=> (st_q == ST_WAIT_CMP));

endmodule

// File: rtl/srch_triplet_regs.sv
module srch_triplet_regs
    import srch_triplet_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              accept_i,
    input  logic              pref_dir_i,
    input  logic              cap_id_i,
    input  logic              cap_cmp_i,
    input  logic              fin_abort_i,
    input  logic              fin_wr_i,
    input  logic              rdata_i,
    input  logic              dir_i,
    output logic              pref_q_o,
    output logic              id_q_o,
    output logic              dir_q_o,
    output logic              done_o,
    output logic [STAT_W-1:0] status_o
);
    logic       pref_q, id_q, cmp_q, dir_q, done_q;
    trip_stat_t stat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pref_q <= 1'b0;
            id_q   <= 1'b0;
            cmp_q  <= 1'b0;
            dir_q  <= 1'b0;
            done_q <= 1'b0;
            stat_q <= '0;
        end else begin
            done_q <= 1'b0;
            if (accept_i)  pref_q <= pref_dir_i;
            if (cap_id_i)  id_q   <= rdata_i;
            if (cap_cmp_i) begin
                cmp_q <= rdata_i;
                dir_q <= dir_i;
            end
            if (fin_abort_i) begin
                stat_q <= '{dir: 1'b0, cmp: 1'b1, id: 1'b1};
                done_q <= 1'b1;
            end else if (fin_wr_i) begin
                stat_q <= '{dir: dir_q, cmp: cmp_q, id: id_q};
                done_q <= 1'b1;
            end
        end
    end

    assign pref_q_o = pref_q;
    assign id_q_o   = id_q;
    assign dir_q_o  = dir_q;
    assign done_o   = done_q;
    assign status_o = stat_q;

endmodule

// File: rtl/srch_triplet.sv
module srch_triplet
    import srch_triplet_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              pref_dir_i,
    output logic              slot_req_o,
    output logic              slot_bit_o,
    input  logic              slot_done_i,
    input  logic              slot_rdata_i,
    output logic              done_o,
    output logic [STAT_W-1:0] status_o
);
    logic accept, cap_id, cap_cmp, fin_abort, fin_wr;
    logic pref_q, id_q, dir_q, abort, dir_new;

    srch_triplet_decide u_decide (
        .id_b_i  (id_q),
        .cmp_b_i (slot_rdata_i),
        .pref_i  (pref_q),
        .abort_o (abort),
        .dir_o   (dir_new)
    );

    srch_triplet_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .slot_done_i (slot_done_i),
        .abort_i     (abort),
        .wr_dir_i    (dir_q),
        .slot_req_o  (slot_req_o),
        .slot_bit_o  (slot_bit_o),
        .accept_o    (accept),
        .cap_id_o    (cap_id),
        .cap_cmp_o   (cap_cmp),
        .fin_abort_o (fin_abort),
        .fin_wr_o    (fin_wr)
    );

    srch_triplet_regs u_regs (
        .clk         (clk),
        .rst         (rst),
        .accept_i    (accept),
        .pref_dir_i  (pref_dir_i),
        .cap_id_i    (cap_id),
        .cap_cmp_i   (cap_cmp),
        .fin_abort_i (fin_abort),
        .fin_wr_i    (fin_wr),
        .rdata_i     (slot_rdata_i),
        .dir_i       (dir_new),
        .pref_q_o    (pref_q),
        .id_q_o      (id_q),
        .dir_q_o     (dir_q),
        .done_o      (done_o),
        .status_o    (status_o)
    );

    // R8: done is a single-cycle pulse
    p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R8: status moves only together with done
    p_status_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> $stable(status_o));

    // R4: the restart code never reports a direction
    p_restart_code_r4: assert property (@(posedge clk) disable iff (rst)
        (done_o && status_o[1:0] == 2'b11) |-> !status_o[2]);

    // R6: a forced direction follows the ID bit
    p_forced_dir_r6: assert property (@(posedge clk) disable iff (rst)
        (done_o && (status_o[0] != status_o[1])) |-> (status_o[2] == status_o[0]));

    // R1: quiet outputs in the first cycle after reset
    p_reset_quiet_r1: assert property (@(posedge clk)
        $past(rst) |-> (!slot_req_o && !done_o && status_o == '0));

endmodule

// File: tb/srch_triplet_bench.sv
module srch_triplet_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0;
    logic       pref_dir_i = 1'b0;
    logic       slot_done_i = 1'b0;
    logic       slot_rdata_i = 1'b0;
    logic       slot_req_o, slot_bit_o, done_o;
    logic [2:0] status_o;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    srch_triplet u_srch_triplet (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .pref_dir_i   (pref_dir_i),
        .slot_req_o   (slot_req_o),
        .slot_bit_o   (slot_bit_o),
        .slot_done_i  (slot_done_i),
        .slot_rdata_i (slot_rdata_i),
        .done_o       (done_o),
        .status_o     (status_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
        end
    endtask

    // Per-clock model of the done pulse: it follows the last slot's done by one edge.
    int done_seen = 0;
    int done_exp  = 0;
    always @(negedge clk) begin
        cycles++;
        if (!rst && done_o) done_seen++;
    end

    task automatic run_trip(input logic idb, input logic cmpb, input logic pref,
                            input int lat, input bit poke);
        logic [2:0] exp_st;
        logic       dir;
        int         nslots;
        logic       held;
        if (idb && cmpb) begin
            exp_st = 3'b011; nslots = 2; dir = 1'b0;
        end else begin
            dir    = (!idb && !cmpb) ? pref : idb;
            exp_st = {dir, cmpb, idb};
            nslots = 3;
        end
        @(negedge clk);
        start_i = 1'b1; pref_dir_i = pref;
        @(negedge clk);
        start_i = 1'b0; pref_dir_i = ~pref;   // R7: late change must not matter
        for (int s = 0; s < nslots; s++) begin
            int n = 0;
            while (!slot_req_o && n < 20) begin
                @(negedge clk); n++;
            end
            chk(slot_req_o, "R2 request issued", slot_req_o, 1);
            chk(slot_bit_o == ((s < 2) ? 1'b1 : dir),
                (s < 2) ? "R2 read slot drives 1" : "R5/R6 written direction",
                slot_bit_o, (s < 2) ? 1 : dir);
            held = slot_bit_o;
            for (int k = 0; k < lat; k++) begin
                @(negedge clk);
                chk(!slot_req_o, "R2 no request while outstanding", slot_req_o, 0);
                chk(slot_bit_o == held, "R7 bit stable in slot", slot_bit_o, held);
                start_i = (poke && s == 1 && k == 0);
            end
            slot_done_i  = 1'b1;
            slot_rdata_i = (s == 0) ? idb : (s == 1) ? cmpb : 1'b1;
            @(negedge clk);
            slot_done_i = 1'b0; start_i = 1'b0;
        end
        done_exp++;
        chk(done_o == 1'b1, "R8 done with status", done_o, 1);
        chk(status_o == exp_st, "R3/R4/R5/R6 status", status_o, exp_st);
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            chk(!slot_req_o, (nslots == 2) ? "R4 no write slot" : "R9 no extra slot",
                slot_req_o, 0);
            chk(!done_o, "R8 single done pulse", done_o, 0);
            chk(status_o == exp_st, "R8 status holds", status_o, exp_st);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!slot_req_o && !done_o && status_o == 3'b000, "R1 reset state",
            {slot_req_o, done_o, status_o}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!slot_req_o && !done_o && status_o == 3'b000, "R1 after reset",
            {slot_req_o, done_o, status_o}, 0);
        run_trip(1'b0, 1'b0, 1'b1, 1, 1'b0);   // R5 -> 100
        run_trip(1'b0, 1'b0, 1'b0, 3, 1'b0);   // R5 -> 000
        run_trip(1'b1, 1'b0, 1'b0, 2, 1'b0);   // R6 -> 101
        run_trip(1'b0, 1'b1, 1'b1, 4, 1'b1);   // R6 -> 010, R9 poke
        run_trip(1'b1, 1'b1, 1'b1, 2, 1'b1);   // R4 -> 011, R9 poke
        run_trip(1'b1, 1'b0, 1'b1, 1, 1'b1);   // R6 with pref 1, R9
        run_trip(1'b0, 1'b0, 1'b1, 6, 1'b1);   // R5 long latency
        chk(done_seen == done_exp, "R8 done count", done_seen, done_exp);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            chk(1'b0, "watchdog", cycles, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule